// File: doc/BRIEF.md
# Configuration Register Slave for a Two-Wire Serial Bus

This block is a target on a two-wire serial management bus (SMBus/I2C style). It runs entirely on a fast system clock. The SCL and SDA pins are sampled through synchronizers and reduced to edge events. The block answers only its own device address. It pulls SDA low through an open-drain enable output when it acknowledges a byte or sends a zero bit.

The block holds six 8-bit configuration registers and presents them on a flat output bus for the clock-output and configuration logic. The first byte after the address is a command byte, and its top bit picks the access type:

- **Byte access** (top bit set): the lower seven bits name a single register offset.
- **Block access** (top bit clear): writes carry a byte count from the master and then fill the registers from offset 0 upward. Reads, after a repeated START, return a count of 6 and then the registers from offset 0 upward.

The master may stop a transfer after any complete byte.

Register reset values and behaviour:

| Offset | Reset value | Behaviour |
|--------|-------------|-----------|
| 0 | 0x07 | Mode bits 7, 6, 2, 1, 0 are writable; bits 5:3 are reserved |
| 1 | 0xFF | Per-output enables, fully writable |
| 2 | 0x00 | Per-output stoppable mask, fully writable |
| 3 | 0x00 | Reserved |
| 4 | 0x08 | Identification byte, read only |
| 5 | 0x00 | Reserved |

Protocol state machine:

| State | Role | Leaves on |
|-------|------|-----------|
| ST_IDLE | Waiting for a START | START → ST_ADDR |
| ST_ADDR | Shifts in the address byte | 8th bit: match → ST_AACK, no match → ST_SKIP |
| ST_AACK | Acknowledges the address | SCL fall: write → ST_RX, read → ST_TX |
| ST_RX | Shifts in a command, count or data byte | 8th bit → ST_RACK |
| ST_RACK | Acknowledges the received byte | SCL fall → ST_RX |
| ST_TX | Shifts out a count or data byte | 8th bit → ST_MACK |
| ST_MACK | Samples the master's acknowledge | ACK → ST_TX, NACK → ST_SKIP |
| ST_SKIP | Ignores the bus | START or STOP |

From any state, a START leads to ST_ADDR and a STOP leads to ST_IDLE.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset, cfg_regs holds reg0=0x07, reg1=0xFF, reg2=0x00, reg3=0x00, reg4=0x08, reg5=0x00, with register i on bits [8i+7:8i].
- R2: The block acknowledges only the address byte 0xDC (address 1101110, write) or 0xDD (read); any other address is not acknowledged, and the rest of that transfer changes no register.
- R3: A command byte with bit 7 = 1 selects byte access at offset bits 6:0; the following data byte is acknowledged and written to that register.
- R4: A byte read (command, repeated START, address with read bit) returns the register at the commanded offset.
- R5: A command byte of 0x00 selects block write. The next byte is a count, which is acknowledged and otherwise unused. Data bytes then go to offsets 0, 1, 2 and upward, and a STOP after any byte leaves the remaining registers unchanged.
- R6: A block read returns the count 0x06 first, then registers from offset 0 upward. A master NACK ends the transfer with SDA released.
- R7: Reserved bits (reg0 bits 5:3, all of reg3 and reg5) and the read-only reg4 ignore writes and keep their reset values.
- R8: Writes to offsets 6 and above are acknowledged but change nothing, and reads from them return 0x00.
- R9: All bytes are shifted most significant bit first.
- R10: A START at any point restarts the address phase, and a STOP at any point returns to idle. A broken transfer leaves the registers unchanged, and the next transfer works normally.
- R11: sda_pull changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_pull | output | 1 | 1 = drive SDA low (open drain) |
| cfg_regs | output | 48 | Register contents, reg i at [8i+7:8i] |

## Verification
A wrong bit counter or a wrong state would make the block acknowledge in the wrong bit slot or skip an acknowledge. This shows on SDA within one byte time of the fault. A wrong pointer or a wrong phase shows later: a register written at the wrong offset appears on cfg_regs at the end of the data byte, and the read data returned after the next repeated START is off. A wrong pull timing would make SDA move while SCL is high, which the bus would read as a false START or STOP.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
    localparam int NREG     = 6;
    localparam int OFFW     = 7;
    localparam logic [6:0] DEV_ADDR = 7'b1101110;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK, ST_TX, ST_MACK, ST_SKIP
    } smb_state_e;

    typedef enum logic [1:0] {
        PH_CMD, PH_COUNT, PH_DATA
    } wr_phase_e;

    function automatic logic [7:0] reg_rst(input int idx);
        case (idx)
            0:       return 8'h07;
            1:       return 8'hFF;
            4:       return 8'h08;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] reg_wmask(input int idx);
        case (idx)
            0:       return 8'hC7;
            1, 2:    return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_chain, sda_chain;
    logic              scl_q, sda_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_chain[g] <= 1'b1;
                    sda_chain[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_chain[g] <= scl_in;
                    sda_chain[g] <= sda_in;
                end else begin
                    scl_chain[g] <= scl_chain[(g == 0) ? 0 : g-1];
                    sda_chain[g] <= sda_chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_chain[STAGES-1];
            sda_q <= sda_chain[STAGES-1];
        end
    end

    assign scl_lvl  = scl_chain[STAGES-1];
    assign sda_lvl  = sda_chain[STAGES-1];
    assign scl_rise = scl_lvl & ~scl_q;
    assign scl_fall = ~scl_lvl & scl_q;
    assign start_ev = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_ev  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/smb_cfg_regfile.sv
module smb_cfg_regfile
    import smb_cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [OFFW-1:0]     wr_idx,
    input  logic [7:0]          wr_data,
    input  logic [OFFW-1:0]     rd_idx,
    output logic [7:0]          rd_data,
    output logic [NREG*8-1:0]   cfg_flat
);
    logic [7:0] regs [NREG];

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            localparam logic [7:0] RV = reg_rst(g);
            localparam logic [7:0] WM = reg_wmask(g);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    regs[g] <= RV;
                else if (wr_en && wr_idx == OFFW'(g))
                    regs[g] <= (wr_data & WM) | (RV & ~WM);
            end
            assign cfg_flat[g*8 +: 8] = regs[g];
        end
    endgenerate

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NREG; i++)
            if (rd_idx == OFFW'(i)) rd_data = regs[i];
    end

    // R8: an out-of-range write leaves every register as it was
    p_oob_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx >= OFFW'(NREG)) |=> (cfg_flat == $past(cfg_flat)));

    // R3: a write to the fully writable enable register lands unchanged
    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == OFFW'(1)) |=> (cfg_flat[15:8] == $past(wr_data)));
endmodule

// File: rtl/smb_xfer_fsm.sv
module smb_xfer_fsm
    import smb_cfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_lvl,
    input  logic            sda_lvl,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            start_ev,
    input  logic            stop_ev,
    input  logic [7:0]      rd_data,
    output logic [OFFW-1:0] ptr,
    output logic            wr_en,
    output logic [OFFW-1:0] wr_idx,
    output logic [7:0]      wr_data,
    output logic            sda_pull
);
    localparam logic [7:0] BLK_COUNT = 8'(NREG);

    smb_state_e state, state_nx;
    wr_phase_e  phase;
    logic [3:0] bit_cnt;
    logic [7:0] shreg;
    logic       pull_q, rw_q, blk_q, nack_q;
    logic       byte_end, addr_hit;

    assign byte_end = scl_fall && (bit_cnt == 4'd8);
    assign addr_hit = (shreg[7:1] == DEV_ADDR);

    // next-state logic
    always_comb begin
        state_nx = state;
        if (start_ev)
            state_nx = ST_ADDR;
        else if (stop_ev)
            state_nx = ST_IDLE;
        else begin
            unique case (state)
                ST_IDLE: state_nx = ST_IDLE;
                ST_ADDR: if (byte_end) state_nx = addr_hit ? ST_AACK : ST_SKIP;
                ST_AACK: if (scl_fall) state_nx = rw_q ? ST_TX : ST_RX;
                ST_RX:   if (byte_end) state_nx = ST_RACK;
                ST_RACK: if (scl_fall) state_nx = ST_RX;
                ST_TX:   if (byte_end) state_nx = ST_MACK;
                ST_MACK: if (scl_fall) state_nx = nack_q ? ST_SKIP : ST_TX;
                ST_SKIP: state_nx = ST_SKIP;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            pull_q  <= 1'b0;
            rw_q    <= 1'b0;
            blk_q   <= 1'b0;
            nack_q  <= 1'b0;
            ptr     <= '0;
            phase   <= PH_CMD;
        end else if (start_ev || stop_ev) begin
            bit_cnt <= '0;
            pull_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_RX: begin
                    if (scl_rise && bit_cnt != 4'd8) begin
                        shreg   <= {shreg[6:0], sda_lvl};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (byte_end) begin
                        if (state == ST_ADDR) begin
                            pull_q <= addr_hit;
                            rw_q   <= shreg[0];
                        end else begin
                            pull_q <= 1'b1;
                            unique case (phase)
                                PH_CMD: begin
                                    blk_q <= ~shreg[7];
                                    ptr   <= shreg[7] ? shreg[6:0] : '0;
                                    phase <= shreg[7] ? PH_DATA : PH_COUNT;
                                end
                                PH_COUNT: phase <= PH_DATA;
                                default:  ptr   <= ptr + OFFW'(1);
                            endcase
                        end
                    end
                end
                ST_AACK: if (scl_fall) begin
                    bit_cnt <= '0;
                    if (!rw_q) begin
                        pull_q <= 1'b0;
                        phase  <= PH_CMD;
                    end else if (blk_q) begin
                        shreg  <= BLK_COUNT;
                        ptr    <= '0;
                        pull_q <= ~BLK_COUNT[7];
                    end else begin
                        shreg  <= rd_data;
                        ptr    <= ptr + OFFW'(1);
                        pull_q <= ~rd_data[7];
                    end
                end
                ST_RACK: if (scl_fall) begin
                    pull_q  <= 1'b0;
                    bit_cnt <= '0;
                end
                ST_TX: begin
                    if (scl_rise && bit_cnt != 4'd8) bit_cnt <= bit_cnt + 4'd1;
                    if (scl_fall) begin
                        if (bit_cnt == 4'd8) pull_q <= 1'b0;
                        else begin
                            shreg  <= {shreg[6:0], 1'b0};
                            pull_q <= ~shreg[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) nack_q <= sda_lvl;
                    if (scl_fall && !nack_q) begin
                        shreg   <= rd_data;
                        ptr     <= ptr + OFFW'(1);
                        pull_q  <= ~rd_data[7];
                        bit_cnt <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign wr_en    = (state == ST_RX) && byte_end && (phase == PH_DATA);
    assign wr_idx   = ptr;
    assign wr_data  = shreg;
    assign sda_pull = pull_q;

    // R11: the data line moves only while the clock line is low
    p_pull_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> !scl_lvl);

    // R2: the address acknowledge slot is reached only on a matching address
    p_ack_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AACK) |-> (shreg[7:1] == DEV_ADDR));

    // R10: a STOP always brings the machine back to idle with SDA released
    p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state == ST_IDLE && !sda_pull));

    // R6: a block read first loads the byte count
    p_count_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AACK && scl_fall && rw_q && blk_q) |=> (shreg == BLK_COUNT));
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
    import smb_cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_in,
    input  logic                sda_in,
    output logic                sda_pull,
    output logic [NREG*8-1:0]   cfg_regs
);
    logic            scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    logic            wr_en;
    logic [OFFW-1:0] ptr, wr_idx;
    logic [7:0]      wr_data, rd_data;

    smb_line_sync #(.STAGES(2)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    smb_xfer_fsm i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .rd_data  (rd_data),
        .ptr      (ptr),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .sda_pull (sda_pull)
    );

    smb_cfg_regfile i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (ptr),
        .rd_data  (rd_data),
        .cfg_flat (cfg_regs)
    );
endmodule

// File: tb/test_smb_cfg_slave.sv
module test_smb_cfg_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 16;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_item_t;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        scl_m = 1'b1, sda_m = 1'b1;
    logic        sda_pull;
    logic [47:0] cfg_regs;
    logic        sda_line;

    int errors = 0, checks = 0, r11_viol = 0;
    exp_item_t   exp_q[$];
    logic [7:0]  act_q[$];

    assign sda_line = sda_m & ~sda_pull;

    smb_cfg_slave i_smb_cfg_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_pull(sda_pull), .cfg_regs(cfg_regs)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    initial forever begin
        @(negedge clk);
        while (act_q.size() > 0 && exp_q.size() > 0) begin
            exp_item_t e;
            logic [7:0] a;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            check(e.tag, {56'h0, a}, {56'h0, e.val});
        end
    end

    // R11 monitor on ports
    logic pull_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && sda_pull !== pull_prev && scl_m) r11_viol++;
        pull_prev <= sda_pull;
    end

    task automatic waitq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; waitq(Q);
        scl_m = 1'b1; waitq(Q);
        sda_m = 1'b0; waitq(Q);
        scl_m = 1'b0; waitq(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; waitq(Q);
        scl_m = 1'b1; waitq(Q);
        sda_m = 1'b1; waitq(Q);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b;    waitq(Q);
        scl_m = 1'b1; waitq(Q);
        scl_m = 1'b0; waitq(Q);
    endtask

    task automatic bit_in(output logic v);
        sda_m = 1'b1; waitq(Q);
        scl_m = 1'b1; waitq(Q/2);
        v = sda_line; waitq(Q/2);
        scl_m = 1'b0; waitq(Q);
    endtask

    task automatic send_raw(input logic [7:0] b, output logic ack_n);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(ack_n);
    endtask

    task automatic send(input logic [7:0] b, input string tag);
        logic ack_n;
        send_raw(b, ack_n);
        check({tag, " ack"}, {63'h0, ack_n}, 64'h0);
    endtask

    task automatic recv(input logic [7:0] exp, input logic last, input string tag);
        logic [7:0] v;
        logic b;
        exp_item_t e;
        e.val = exp; e.tag = tag;
        exp_q.push_back(e);
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        bit_out(last);
        act_q.push_back(v);
    endtask

    task automatic byte_write(input logic [6:0] off, input logic [7:0] d, input string tag);
        bus_start;
        send(8'hDC, tag);
        send({1'b1, off}, tag);
        send(d, tag);
        bus_stop;
    endtask

    task automatic byte_read(input logic [6:0] off, input logic [7:0] exp, input string tag);
        bus_start;
        send(8'hDC, tag);
        send({1'b1, off}, tag);
        bus_start;
        send(8'hDD, tag);
        recv(exp, 1'b1, tag);
        bus_stop;
    endtask

    task automatic block_read_all(input logic [47:0] exp, input string tag);
        bus_start;
        send(8'hDC, tag);
        send(8'h00, tag);
        bus_start;
        send(8'hDD, tag);
        recv(8'h06, 1'b0, {tag, " count"});
        for (int i = 0; i < 6; i++) recv(exp[i*8 +: 8], (i == 5), tag);
        bus_stop;
    endtask

    initial begin
        logic ack_n;
        waitq(5);
        // R1: reset values
        check("R1 reset cfg", {16'h0, cfg_regs}, {16'h0, 48'h00_08_00_00_FF_07});
        rst_n = 1'b1;
        waitq(5);
        check("R1 idle sda", {63'h0, sda_pull}, 64'h0);

        // R3 byte write, R9 msb-first
        byte_write(7'd2, 8'hA5, "R3");
        check("R3 reg2", {56'h0, cfg_regs[23:16]}, {56'h0, 8'hA5});
        // R4 byte reads
        byte_read(7'd2, 8'hA5, "R4 reg2");
        byte_read(7'd4, 8'h08, "R4 reg4");

        // R2 wrong address
        bus_start;
        send_raw(8'hDE, ack_n);
        check("R2 nack", {63'h0, ack_n}, 64'h1);
        send_raw(8'h81, ack_n);
        send_raw(8'h00, ack_n);
        bus_stop;
        check("R2 cfg unchanged", {16'h0, cfg_regs}, {16'h0, 48'h00_08_00_A5_FF_07});

        // R5 block write with count, R7 reserved bits of reg0
        bus_start;
        send(8'hDC, "R5");
        send(8'h00, "R5");
        send(8'h03, "R5 count");
        send(8'hFF, "R5");
        send(8'h3C, "R5");
        send(8'h81, "R5");
        bus_stop;
        check("R5 block write", {16'h0, cfg_regs}, {16'h0, 48'h00_08_00_81_3C_C7});

        // R5 early stop after one byte
        bus_start;
        send(8'hDC, "R5");
        send(8'h00, "R5");
        send(8'h06, "R5 count");
        send(8'h01, "R5");
        bus_stop;
        check("R5 early stop", {16'h0, cfg_regs}, {16'h0, 48'h00_08_00_81_3C_01});

        // R6 block read full
        block_read_all(48'h00_08_00_81_3C_01, "R6 block");

        // R6 partial block read, SDA released after NACK
        bus_start;
        send(8'hDC, "R6");
        send(8'h00, "R6");
        bus_start;
        send(8'hDD, "R6");
        recv(8'h06, 1'b0, "R6 count");
        recv(8'h01, 1'b1, "R6 partial");
        waitq(Q);
        check("R6 released", {63'h0, sda_line}, 64'h1);
        bus_stop;
        byte_read(7'd1, 8'h3C, "R6 after partial");

        // R7 reserved and read-only registers
        byte_write(7'd3, 8'hFF, "R7");
        byte_write(7'd4, 8'hFF, "R7");
        byte_write(7'd5, 8'hFF, "R7");
        byte_write(7'd0, 8'hFF, "R7");
        check("R7 cfg", {16'h0, cfg_regs}, {16'h0, 48'h00_08_00_81_3C_C7});
        block_read_all(48'h00_08_00_81_3C_C7, "R7 readback");

        // R8 out-of-range offsets
        byte_write(7'h10, 8'h55, "R8");
        check("R8 cfg unchanged", {16'h0, cfg_regs}, {16'h0, 48'h00_08_00_81_3C_C7});
        byte_read(7'h10, 8'h00, "R8 read");
        byte_read(7'd6, 8'h00, "R8 read6");

        // R10 START mid-address, then STOP mid-command
        bus_start;
        bit_out(1'b1); bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
        bus_start;
        send(8'hDC, "R10");
        send(8'h81, "R10");
        send(8'h5A, "R10");
        bus_stop;
        check("R10 restart write", {56'h0, cfg_regs[15:8]}, {56'h0, 8'h5A});
        bus_start;
        send(8'hDC, "R10");
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b0);
        bus_stop;
        check("R10 abort cfg", {16'h0, cfg_regs}, {16'h0, 48'h00_08_00_81_5A_C7});
        byte_read(7'd1, 8'h5A, "R10 read");

        // R9 single MSB set
        byte_write(7'd2, 8'h80, "R9");
        check("R9 msb first", {56'h0, cfg_regs[23:16]}, {56'h0, 8'h80});

        waitq(4);
        check("R6 scoreboard drained", {32'h0, 32'(exp_q.size())}, 64'h0);
        check("R11 no sda move with scl high", {32'h0, 32'(r11_viol)}, 64'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule